// File: doc/BRIEF.md
# SD Card Clock Generator with Timeout Counter

This block derives the SD card clock from the core clock with an 11-bit programmable divider. The programmed value is the divide ratio less two, so the card clock runs at core/(value+2). The fastest setting is half the core rate. The largest value, 0x7ff, gives the slowest rate, and no value stops the clock. One programmed divider serves every phase of card operation, and nothing switches automatically between identification and data rates. Besides the card clock the block emits a one-cycle enable strobe at the start of every card clock period. The rest of the host uses this strobe to step its own logic in the core clock domain.

The block also holds a data/busy timeout counter. A 32-bit start value is written through its own write port. An arm request loads the counter from that value. While armed, the counter counts card clock periods, and when it runs out it emits a one-cycle pulse toward the status logic. The start value after reset is 0xF00000, which is long enough to act as no limit in practice.

Top module: `sd_clkgen_timeout`

## Requirements
- R1: While `rst` is high at a clock edge, `sd_clk`, `sd_clk_en` and `tmo_pulse` are 0 after that edge. The divider value becomes 0, the timeout is disarmed and the start value becomes 0xF00000. The first period after reset has ratio 2 and begins at the first edge with `rst` low.
- R2: With divider value V, `sd_clk_en` is high for exactly one core cycle in every V+2 core cycles. It is high in the same cycle in which `sd_clk` goes from 0 to 1.
- R3: Within a period of N=V+2 core cycles, `sd_clk` is high for the first floor(N/2) cycles and low for the other N-floor(N/2). For example, V=1 gives 1 high and 2 low, and V=5 gives 3 high and 4 low.
- R4: The divider value is 11 bits wide. V=0x7ff gives the longest period of 2049 core cycles, with 1024 of them high. The clock keeps running at every value.
- R5: A divider write that lands in the middle of a period does not change that period, which completes with its old length. The new value governs every period from the next `sd_clk_en` onward.
- R6: A pulse on `tmo_wr_en` stores `tmo_wr_val` as the start value. `tmo_arm` loads the counter from the start value held before that edge and arms it. While armed, the counter is decremented once for each cycle in which `sd_clk_en` is high.
- R7: With start value S≥1, `tmo_pulse` is high for exactly one cycle, in the cycle after the S-th `sd_clk_en` that the armed counter sees. A start value of 0 behaves as 1. The counter is then disarmed, and no further pulse follows without a new arm.
- R8: `tmo_stop` disarms the counter, and no pulse follows. When `tmo_arm` and `tmo_stop` are high together, the arm takes effect and the stop is ignored.
- R9: An arm while already armed reloads the counter, and the count restarts from the full start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| div_wr_en | input | 1 | Write strobe for the divider value |
| div_wr_val | input | 11 | Divider value (divide ratio minus two) |
| tmo_wr_en | input | 1 | Write strobe for the timeout start value |
| tmo_wr_val | input | 32 | Timeout start value, counted in card clock periods |
| tmo_arm | input | 1 | Load the counter from the start value and arm it |
| tmo_stop | input | 1 | Disarm the counter |
| sd_clk | output | 1 | Card clock, registered |
| sd_clk_en | output | 1 | One-cycle strobe at the start of each card clock period |
| tmo_pulse | output | 1 | One-cycle timeout expiry pulse |

## Verification
The hardest case to reach is a divider write that arrives partway through a period. It must leave that period intact and change only the periods that follow. The stimulus first waits for a period start at a long ratio, injects the write a few cycles later, and measures both the interrupted period and the one after it. The expiry pulse is the other timing-sensitive case. Its cycle is predicted by counting strobes seen after the arm edge, so an arm that coincides with a strobe, a reload while armed and an arm paired with a stop all exercise the priority order.

// File: rtl/sd_clkgen_pkg.sv
package sd_clkgen_pkg;
  localparam int unsigned DIV_W_DEF   = 11;
  localparam int unsigned TMO_W_DEF   = 32;
  localparam logic [31:0] TMO_RST_DEF = 32'h00F0_0000;

  // divide ratio from a programmed value: ratio = value + 2
  function automatic logic [DIV_W_DEF:0] ratio_of(input logic [DIV_W_DEF-1:0] v);
    return {1'b0, v} + (DIV_W_DEF+1)'(2);
  endfunction
endpackage

// File: rtl/sd_clk_divider.sv
module sd_clk_divider #(
  parameter int unsigned DIV_W = sd_clkgen_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [DIV_W-1:0] wr_val,
  output logic             sd_clk,
  output logic             sd_clk_en
);
  localparam int unsigned RW = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic [RW-1:0]    ratio_q, cnt_q;
  logic [RW-1:0]    ratio_n, cnt_n, half_n;
  logic             boundary;

  assign boundary = (cnt_q == ratio_q - RW'(1));

  always_comb begin
    if (boundary) begin
      cnt_n   = '0;
      ratio_n = {1'b0, div_q} + RW'(2);
    end else begin
      cnt_n   = cnt_q + RW'(1);
      ratio_n = ratio_q;
    end
    half_n = ratio_n >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= '0;
      ratio_q   <= RW'(2);
      cnt_q     <= RW'(1);
      sd_clk    <= 1'b0;
      sd_clk_en <= 1'b0;
    end else begin
      if (wr_en) div_q <= wr_val;
      cnt_q     <= cnt_n;
      ratio_q   <= ratio_n;
      sd_clk    <= (cnt_n < half_n);
      sd_clk_en <= boundary;
    end
  end

  assert_en_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
    sd_clk_en |-> $rose(sd_clk));
  assert_rise_has_en_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sd_clk) |-> sd_clk_en);
  assert_ratio_held_R5: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(ratio_q));
  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q < ratio_q);
endmodule

// File: rtl/sd_tmo_counter.sv
module sd_tmo_counter #(
  parameter int unsigned      TMO_W   = sd_clkgen_pkg::TMO_W_DEF,
  parameter logic [TMO_W-1:0] RST_VAL = TMO_W'(sd_clkgen_pkg::TMO_RST_DEF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [TMO_W-1:0] wr_val,
  input  logic             arm,
  input  logic             stop,
  output logic             pulse
);
  logic [TMO_W-1:0] start_q, cnt_q;
  logic             armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= RST_VAL;
      cnt_q   <= '0;
      armed_q <= 1'b0;
      pulse   <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (wr_en) start_q <= wr_val;
      if (arm) begin
        cnt_q   <= start_q;
        armed_q <= 1'b1;
      end else if (stop) begin
        armed_q <= 1'b0;
      end else if (armed_q && tick) begin
        if (cnt_q <= TMO_W'(1)) begin
          cnt_q   <= '0;
          armed_q <= 1'b0;
          pulse   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - TMO_W'(1);
        end
      end
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  assert_pulse_disarms_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |-> !armed_q);
  assert_count_only_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (!arm && !(armed_q && tick)) |=> $stable(cnt_q));
  assert_stop_disarms_R8: assert property (@(posedge clk) disable iff (rst)
    (stop && !arm) |=> (!armed_q && !pulse));
endmodule

// File: rtl/sd_clkgen_timeout.sv
module sd_clkgen_timeout #(
  parameter int unsigned DIV_W = sd_clkgen_pkg::DIV_W_DEF,
  parameter int unsigned TMO_W = sd_clkgen_pkg::TMO_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             div_wr_en,
  input  logic [DIV_W-1:0] div_wr_val,
  input  logic             tmo_wr_en,
  input  logic [TMO_W-1:0] tmo_wr_val,
  input  logic             tmo_arm,
  input  logic             tmo_stop,
  output logic             sd_clk,
  output logic             sd_clk_en,
  output logic             tmo_pulse
);
  logic clk_en_w;

  sd_clk_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .wr_en(div_wr_en), .wr_val(div_wr_val),
    .sd_clk(sd_clk), .sd_clk_en(clk_en_w)
  );

  sd_tmo_counter #(.TMO_W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .tick(clk_en_w), .wr_en(tmo_wr_en),
    .wr_val(tmo_wr_val), .arm(tmo_arm), .stop(tmo_stop), .pulse(tmo_pulse)
  );

  assign sd_clk_en = clk_en_w;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!sd_clk && !sd_clk_en && !tmo_pulse));
endmodule

// File: tb/sd_clkgen_timeout_bench.sv
module sd_clkgen_timeout_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        div_wr_en;
  logic [10:0] div_wr_val;
  logic        tmo_wr_en;
  logic [31:0] tmo_wr_val;
  logic        tmo_arm, tmo_stop;
  logic        sd_clk, sd_clk_en, tmo_pulse;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sd_clkgen_timeout u_sd_clkgen_timeout (
    .clk(clk), .rst(rst), .div_wr_en(div_wr_en), .div_wr_val(div_wr_val),
    .tmo_wr_en(tmo_wr_en), .tmo_wr_val(tmo_wr_val), .tmo_arm(tmo_arm),
    .tmo_stop(tmo_stop), .sd_clk(sd_clk), .sd_clk_en(sd_clk_en),
    .tmo_pulse(tmo_pulse)
  );

  // {divider value, expected period, expected high cycles}
  localparam logic [35:0] VEC [0:7] = '{
    {12'd0,    12'd2,    12'd1},
    {12'd1,    12'd3,    12'd1},
    {12'd2,    12'd4,    12'd2},
    {12'd3,    12'd5,    12'd2},
    {12'd5,    12'd7,    12'd3},
    {12'd10,   12'd12,   12'd6},
    {12'd31,   12'd33,   12'd16},
    {12'h7ff,  12'd2049, 12'd1024}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input logic [10:0] v);
    div_wr_en = 1'b1; div_wr_val = v;
    @(negedge clk);
    div_wr_en = 1'b0;
  endtask

  task automatic wr_tmo(input logic [31:0] v);
    tmo_wr_en = 1'b1; tmo_wr_val = v;
    @(negedge clk);
    tmo_wr_en = 1'b0;
  endtask

  task automatic wait_en();
    for (int i = 0; i < 5000; i++) begin
      if (sd_clk_en) return;
      @(negedge clk);
    end
  endtask

  // called at a negedge with sd_clk_en high; ends at the next one
  task automatic measure(output int per, output int hi,
                         input int inj_at, input logic [10:0] inj_val);
    per = 1; hi = sd_clk ? 1 : 0;
    for (int i = 0; i < 5000; i++) begin
      if (i == inj_at) begin div_wr_en = 1'b1; div_wr_val = inj_val; end
      @(negedge clk);
      div_wr_en = 1'b0;
      if (sd_clk_en) return;
      per++;
      if (sd_clk) hi++;
    end
  endtask

  // arms (optionally with stop) and checks the pulse arrives after the
  // s-th strobe seen, lasting one cycle
  task automatic tmo_run(input int s, input bit with_stop, input string req);
    int sth = (s == 0) ? 1 : s;
    int seen = 0;
    int fired = 0;
    int bad = 0;
    bit fire_next = 1'b0;
    tmo_arm = 1'b1; tmo_stop = with_stop;
    @(negedge clk);
    tmo_arm = 1'b0; tmo_stop = 1'b0;
    for (int i = 0; i < 400 && seen <= sth + 2; i++) begin
      if (tmo_pulse !== fire_next) bad++;
      if (tmo_pulse) fired++;
      fire_next = sd_clk_en && (seen + 1 == sth);
      if (sd_clk_en) seen++;
      @(negedge clk);
    end
    chk({req, " pulse count"}, fired, 1);
    chk({req, " pulse timing"}, bad, 0);
  endtask

  task automatic quiet(input int n, input string req);
    int fired = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tmo_pulse) fired++;
    end
    chk(req, fired, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int per, hi;
    rst = 1'b1; div_wr_en = 1'b0; div_wr_val = '0; tmo_wr_en = 1'b0;
    tmo_wr_val = '0; tmo_arm = 1'b0; tmo_stop = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sd_clk", int'(sd_clk), 0);
    chk("R1 sd_clk_en", int'(sd_clk_en), 0);
    chk("R1 tmo_pulse", int'(tmo_pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first strobe", int'(sd_clk_en), 1);
    measure(per, hi, -1, '0);
    chk("R1 reset divider period", per, 2);

    // R2 R3 R4 vector table
    foreach (VEC[k]) begin
      wr_div(VEC[k][35:24]);
      wait_en(); @(negedge clk); wait_en();
      measure(per, hi, -1, '0);
      chk($sformatf("R2 period div=%0d", VEC[k][35:24]), per, int'(VEC[k][23:12]));
      chk($sformatf("R3 high div=%0d", VEC[k][35:24]), hi, int'(VEC[k][11:0]));
    end
    measure(per, hi, -1, '0);
    chk("R4 slowest keeps running", per, 2049);

    // R5 mid-period change
    wr_div(11'd10);
    wait_en(); @(negedge clk); wait_en();
    measure(per, hi, 3, 11'd0);
    chk("R5 current period kept", per, 12);
    chk("R5 current high kept", hi, 6);
    measure(per, hi, -1, '0);
    chk("R5 new period", per, 2);

    // timeout, divider at 0 then 1
    wr_div(11'd1);
    wait_en(); @(negedge clk); wait_en();
    wr_tmo(32'd3);
    tmo_run(3, 1'b0, "R6 R7 start=3");
    quiet(30, "R7 no second pulse");
    wr_tmo(32'd0);
    tmo_run(0, 1'b0, "R7 start=0");
    wr_tmo(32'd1);
    tmo_run(1, 1'b0, "R7 start=1");

    // R8 stop
    wr_tmo(32'd5);
    tmo_arm = 1'b1; @(negedge clk); tmo_arm = 1'b0;
    repeat (4) @(negedge clk);
    tmo_stop = 1'b1; @(negedge clk); tmo_stop = 1'b0;
    quiet(60, "R8 stop disarms");
    wr_tmo(32'd2);
    tmo_run(2, 1'b1, "R8 arm beats stop");

    // R9 rearm restarts full count
    wr_tmo(32'd4);
    tmo_arm = 1'b1; @(negedge clk); tmo_arm = 1'b0;
    quiet(8, "R9 no early pulse");
    tmo_run(4, 1'b0, "R9 rearm reload");

    // R1 reset disarms and restores start value
    wr_tmo(32'd3);
    tmo_arm = 1'b1; @(negedge clk); tmo_arm = 1'b0;
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    quiet(40, "R1 reset disarms");
    tmo_arm = 1'b1; @(negedge clk); tmo_arm = 1'b0;
    quiet(300, "R1 reset start value large");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule